// File: doc/BRIEF.md
# Self-Calibrating Wake-Up Timer

This block produces periodic wake-up pulses for a low-power system. It is clocked by a cheap slow oscillator whose frequency is only roughly known. It learns how many slow cycles make up one millisecond by measuring them against a reference tick that is derived from a crystal. From that figure it builds a millisecond time base. A programmable interval of mantissa times a power of two milliseconds is counted on that time base, and a one-cycle timeout pulse is raised each time the interval ends.

The crystal is only needed while a measurement is running. The block raises an oscillator request when a calibration is due and waits for the oscillator to report ready. It then times a fixed window of reference ticks and drops the request once the result is stored. A calibration runs each time the block is enabled. After that it runs again at a fixed number of calibrated milliseconds, thirty thousand by default. This keeps the slow time base accurate as temperature and supply drift.

Top module: `wkt_top`

## Requirements
- R1: While reset is held, and afterwards while `en` is low, `osc_req` and `timeout` stay low.
- R2: When `en` rises, `osc_req` goes high on the next cycle and stays high until a calibration has been stored. No measurement starts while `osc_ok` is low, so no timeout can appear before `osc_ok` has been high. With a steady reference period P, the request stays high for at least 4·P and at most 5·P+8 cycles counted from its rise. This assumes `osc_ok` follows the request within three cycles.
- R3: A calibration aligns on a reference tick and adds up the slow cycles over the next 2^CAL_LOG2 tick intervals. It stores that sum divided by 2^CAL_LOG2, rounded half up, with a floor of 2. The millisecond base then ticks once every stored-value slow cycles. Example: with a window of 4 and intervals of 7,8,7,8 the stored value is 8. With a reference tick present on every cycle it is 2.
- R4: With mantissa M (unsigned, 1 to 255) and exponent E (unsigned), consecutive timeout pulses are exactly M·2^E·C slow cycles apart, where C is the stored calibration value.
- R5: Every timeout pulse is one cycle wide, and the interval count reloads by itself after each pulse.
- R6: While the mantissa is 0, no timeout pulse is produced. Calibration still runs.
- R7: When enabled, a new calibration begins every RECAL_MS millisecond ticks, counted from the start of the previous one. With a steady calibration value C, successive rises of `osc_req` after the first are RECAL_MS·C cycles apart.
- R8: A recalibration replaces the stored value. Once the current interval has run out, timeout spacing follows the newly measured reference period.
- R9: Lowering `en` drops `osc_req` on the next cycle, even in the middle of a calibration. It suppresses all timeouts and discards the calibration. Raising `en` again starts a fresh calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Timer enable; low clears calibration and stops all activity |
| period_mant | input | MANT_W | Interval mantissa in milliseconds; 0 silences timeouts |
| period_exp | input | EXP_W | Interval exponent (power-of-two multiplier) |
| ref_tick | input | 1 | One-cycle pulse per crystal-derived millisecond, synchronous to `clk` |
| osc_ok | input | 1 | Crystal oscillator reports running |
| osc_req | output | 1 | Request to power the crystal oscillator |
| timeout | output | 1 | One-cycle wake-up pulse |

## Verification
The assertions rely on a few conditions at the inputs. `ref_tick` must be a single-cycle pulse that is already synchronous to the slow clock. `osc_ok` must rise only after a request. The period fields must stay steady while the block is enabled, because a change mid-interval only takes effect at the next reload. The stimulus meets these conditions in three ways. It changes the mantissa and exponent only while `en` is low. It changes the reference spacing only while no calibration is in progress, and allows several reference periods to pass before a new window can start. It models the oscillator as a three-cycle delayed echo of the request, which can be held off on purpose. Expected spacings come from M·2^E times the rounded window average, and are computed in the bench.

// File: rtl/wkt_pkg.sv
package wkt_pkg;

   typedef enum logic [1:0] {
      CAL_IDLE  = 2'd0,
      CAL_WAIT  = 2'd1,
      CAL_ALIGN = 2'd2,
      CAL_MEAS  = 2'd3
   } cal_state_e;

endpackage

// File: rtl/wkt_calib.sv
module wkt_calib
   import wkt_pkg::*;
#(
   parameter int CYC_W     = 12,
   parameter int CAL_LOG2  = 2,
   parameter bit ROUND_CAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             start,
   input  logic             osc_ok,
   input  logic             ref_tick,
   output logic             osc_req,
   output logic             idle,
   output logic             cal_valid,
   output logic [CYC_W-1:0] cal_q
);

   localparam int SUM_W = CYC_W + CAL_LOG2 + 1;
   localparam int WIN   = 1 << CAL_LOG2;
   localparam logic [SUM_W-1:0]    SUM_MAX = {1'b0, {(SUM_W-1){1'b1}}};
   localparam logic [SUM_W-1:0]    CAL_MAX = {{(SUM_W-CYC_W){1'b0}}, {CYC_W{1'b1}}};
   localparam logic [SUM_W-1:0]    CAL_MIN = SUM_W'(2);
   localparam logic [CAL_LOG2-1:0] TK_LAST = CAL_LOG2'(WIN - 1);

   cal_state_e          st;
   logic [SUM_W-1:0]    sum;
   logic [SUM_W-1:0]    sum_inc;
   logic [SUM_W-1:0]    quo;
   logic [CAL_LOG2-1:0] tk;
   logic [CYC_W-1:0]    cal_new;

   // saturating cycle accumulator; top bit kept free for the rounding bias
   assign sum_inc = (sum == SUM_MAX) ? SUM_MAX : sum + 1'b1;

   if (ROUND_CAL) begin : g_round
      logic [SUM_W-1:0] biased;
      assign biased = sum_inc + SUM_W'(WIN / 2);
      assign quo    = biased >> CAL_LOG2;
   end else begin : g_trunc
      assign quo = sum_inc >> CAL_LOG2;
   end

   always_comb begin
      if (quo < CAL_MIN) begin
         cal_new = CYC_W'(2);
      end else if (quo > CAL_MAX) begin
         cal_new = {CYC_W{1'b1}};
      end else begin
         cal_new = quo[CYC_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= CAL_IDLE;
         sum       <= '0;
         tk        <= '0;
         cal_valid <= 1'b0;
         cal_q     <= CYC_W'(2);
      end else if (!en) begin
         st        <= CAL_IDLE;
         cal_valid <= 1'b0;
      end else begin
         unique case (st)
            CAL_IDLE: begin
               if (start) st <= CAL_WAIT;
            end
            CAL_WAIT: begin
               if (osc_ok) st <= CAL_ALIGN;
            end
            CAL_ALIGN: begin
               if (!osc_ok) begin
                  st <= CAL_WAIT;
               end else if (ref_tick) begin
                  st  <= CAL_MEAS;
                  sum <= '0;
                  tk  <= '0;
               end
            end
            CAL_MEAS: begin
               if (!osc_ok) begin
                  st <= CAL_WAIT;
               end else begin
                  sum <= sum_inc;
                  if (ref_tick) begin
                     if (tk == TK_LAST) begin
                        st        <= CAL_IDLE;
                        cal_q     <= cal_new;
                        cal_valid <= 1'b1;
                     end else begin
                        tk <= tk + 1'b1;
                     end
                  end
               end
            end
            default: st <= CAL_IDLE;
         endcase
      end
   end

   assign osc_req = (st != CAL_IDLE);
   assign idle    = (st == CAL_IDLE);

   // R2: the request only drops after a stored result or a disable
   a_r2_req_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(osc_req) |-> (cal_valid || !$past(en)));

   // R2: a result is only stored while the oscillator reports ready
   a_r2_ready_before_store: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_valid) |-> $past(osc_ok));

endmodule

// File: rtl/wkt_msbase.sv
module wkt_msbase #(
   parameter int CYC_W    = 12,
   parameter int RECAL_MS = 30000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             cal_valid,
   input  logic [CYC_W-1:0] cal_q,
   input  logic             start,
   output logic             ms_tick,
   output logic             recal_due
);

   logic [CYC_W-1:0] msc;
   logic             run;

   assign run     = en && cal_valid;
   assign ms_tick = run && (msc >= cal_q - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msc <= '0;
      end else if (!run || ms_tick) begin
         msc <= '0;
      end else begin
         msc <= msc + 1'b1;
      end
   end

   if (RECAL_MS == 0) begin : g_norecal
      assign recal_due = 1'b0;
   end else begin : g_recal
      localparam int RC_W = $clog2(RECAL_MS + 2);
      localparam logic [RC_W-1:0] RC_LAST = RC_W'(RECAL_MS);
      logic [RC_W-1:0] rc;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rc <= '0;
         end else if (!en || start) begin
            rc <= '0;
         end else if (ms_tick && (rc != RC_LAST)) begin
            rc <= rc + 1'b1;
         end
      end

      assign recal_due = (rc == RC_LAST);
   end

   // R3: with a floor of two cycles per millisecond, ticks never touch
   a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ms_tick |=> !ms_tick);

endmodule

// File: rtl/wkt_interval.sv
module wkt_interval #(
   parameter int MANT_W = 8,
   parameter int EXP_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              ms_tick,
   input  logic [MANT_W-1:0] mant,
   input  logic [EXP_W-1:0]  expo,
   output logic              timeout
);

   localparam int IV_W = MANT_W + (1 << EXP_W) - 1;

   logic [IV_W-1:0] ivc;
   logic [IV_W-1:0] load;
   logic            silent;

   assign load   = IV_W'(mant) << expo;
   assign silent = (mant == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ivc <= '0;
      end else if (!run || silent) begin
         ivc <= load;
      end else if (ms_tick) begin
         ivc <= (ivc <= IV_W'(1)) ? load : ivc - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         timeout <= 1'b0;
      end else begin
         timeout <= run && ms_tick && !silent && (ivc == IV_W'(1));
      end
   end

   // R5: single-cycle wake pulse
   a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> !timeout);

   // R6: a zero mantissa never produces a pulse
   a_r6_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> $past(mant != '0));

endmodule

// File: rtl/wkt_top.sv
module wkt_top #(
   parameter int MANT_W    = 8,
   parameter int EXP_W     = 5,
   parameter int CYC_W     = 12,
   parameter int CAL_LOG2  = 2,
   parameter int RECAL_MS  = 30000,
   parameter bit ROUND_CAL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [MANT_W-1:0] period_mant,
   input  logic [EXP_W-1:0]  period_exp,
   input  logic              ref_tick,
   input  logic              osc_ok,
   output logic              osc_req,
   output logic              timeout
);

   if (MANT_W < 1 || EXP_W < 1 || EXP_W > 6) begin : g_bad_period
      $error("wkt_top: period field widths out of range");
   end
   if (CYC_W < 2 || CYC_W > 24) begin : g_bad_cyc
      $error("wkt_top: CYC_W must lie in 2..24");
   end
   if (CAL_LOG2 < 1 || CAL_LOG2 > 8) begin : g_bad_win
      $error("wkt_top: CAL_LOG2 must lie in 1..8");
   end
   if (RECAL_MS < 0) begin : g_bad_recal
      $error("wkt_top: RECAL_MS must not be negative");
   end

   logic             cal_idle;
   logic             cal_valid;
   logic [CYC_W-1:0] cal_q;
   logic             ms_tick;
   logic             recal_due;
   logic             cal_start;

   assign cal_start = en && cal_idle && (!cal_valid || recal_due);

   wkt_calib #(
      .CYC_W     (CYC_W),
      .CAL_LOG2  (CAL_LOG2),
      .ROUND_CAL (ROUND_CAL)
   ) u_calib (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .start     (cal_start),
      .osc_ok    (osc_ok),
      .ref_tick  (ref_tick),
      .osc_req   (osc_req),
      .idle      (cal_idle),
      .cal_valid (cal_valid),
      .cal_q     (cal_q)
   );

   wkt_msbase #(
      .CYC_W    (CYC_W),
      .RECAL_MS (RECAL_MS)
   ) u_msbase (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .cal_valid (cal_valid),
      .cal_q     (cal_q),
      .start     (cal_start),
      .ms_tick   (ms_tick),
      .recal_due (recal_due)
   );

   wkt_interval #(
      .MANT_W (MANT_W),
      .EXP_W  (EXP_W)
   ) u_interval (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en && cal_valid),
      .ms_tick (ms_tick),
      .mant    (period_mant),
      .expo    (period_exp),
      .timeout (timeout)
   );

   // R9 and R1: disabled means no request and no pulse
   a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!osc_req && !timeout));

endmodule

// File: tb/wkt_top_tb.sv
module wkt_top_tb;

   localparam int CLK_PERIOD = 10;
   localparam int MANT_W     = 8;
   localparam int EXP_W      = 5;
   localparam int CYC_W      = 10;
   localparam int CAL_LOG2   = 2;
   localparam int WIN        = 1 << CAL_LOG2;
   localparam int RECAL_MS   = 30;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              en = 1'b0;
   logic [MANT_W-1:0] period_mant = '0;
   logic [EXP_W-1:0]  period_exp = '0;
   logic              ref_tick = 1'b0;
   logic              osc_ok;
   logic              osc_req;
   logic              timeout;

   logic [2:0] osc_pipe = '0;
   logic       osc_hold = 1'b0;
   int         per_a = 7;
   int         per_b = 7;
   longint     cyc = 0;
   int         total = 0;
   int         bad = 0;

   wkt_top #(
      .MANT_W    (MANT_W),
      .EXP_W     (EXP_W),
      .CYC_W     (CYC_W),
      .CAL_LOG2  (CAL_LOG2),
      .RECAL_MS  (RECAL_MS),
      .ROUND_CAL (1'b1)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en),
      .period_mant (period_mant),
      .period_exp  (period_exp),
      .ref_tick    (ref_tick),
      .osc_ok      (osc_ok),
      .osc_req     (osc_req),
      .timeout     (timeout)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   // oscillator model: ready three cycles after the request, unless held off
   always @(negedge clk) osc_pipe <= {osc_pipe[1:0], osc_req};
   assign osc_ok = osc_pipe[2] && !osc_hold;

   // reference ticks with alternating spacing per_a, per_b
   initial begin
      forever begin
         repeat (per_a - 1) @(negedge clk);
         ref_tick = 1'b1;
         @(negedge clk);
         ref_tick = 1'b0;
         repeat (per_b - 1) @(negedge clk);
         ref_tick = 1'b1;
         @(negedge clk);
         ref_tick = 1'b0;
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input longint act, input longint lo, input longint hi);
      total++;
      if (act < lo || act > hi) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   function automatic int exp_cal(input int a, input int b);
      int s;
      int q;
      s = 2 * a + 2 * b;
      q = (s + WIN / 2) / WIN;
      return (q < 2) ? 2 : q;
   endfunction

   task automatic wait_tmo(output longint t, input int lim);
      t = -1;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         if (timeout) begin
            t = cyc;
            return;
         end
      end
   endtask

   task automatic wait_req(input logic lvl, output longint t, input int lim);
      t = -1;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         if (osc_req == lvl) begin
            t = cyc;
            return;
         end
      end
   endtask

   task automatic count_tmo(input int n, output int k);
      k = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (timeout) k++;
      end
   endtask

   task automatic setup(input int m, input int r, input int a, input int b);
      @(negedge clk);
      en          = 1'b0;
      period_mant = MANT_W'(m);
      period_exp  = EXP_W'(r);
      per_a       = a;
      per_b       = b;
      repeat (30) @(negedge clk);
   endtask

   task automatic run_combo(input string tag, input int m, input int r, input int a, input int b);
      longint t0, t1, t2, gap;
      int     lim;
      setup(m, r, a, b);
      en  = 1'b1;
      gap = longint'(m) * (longint'(1) << r) * longint'(exp_cal(a, b));
      lim = int'(gap) * 2 + 300;
      wait_tmo(t0, lim);
      @(negedge clk);
      chk("R5 pulse width", longint'(timeout), 0);
      wait_tmo(t1, lim);
      wait_tmo(t2, lim);
      chk(tag, t1 - t0, gap);
      chk(tag, t2 - t1, gap);
   endtask

   initial begin
      int     k;
      longint ra, fa, rb, fb, rc2, t0, t1, t2, t3;
      int     mv[4] = '{1, 2, 3, 5};
      int     rv[4] = '{0, 1, 2, 5};

      // R1: reset and disabled state
      repeat (5) @(negedge clk);
      chk("R1 req in reset", longint'(osc_req), 0);
      chk("R1 tmo in reset", longint'(timeout), 0);
      rst_n = 1'b1;
      count_tmo(100, k);
      chk("R1 no tmo while off", k, 0);
      chk("R1 no req while off", longint'(osc_req), 0);

      // R2: request rises next cycle and waits for oscillator ready
      setup(1, 0, 7, 7);
      osc_hold = 1'b1;
      en = 1'b1;
      @(negedge clk);
      chk("R2 req after enable", longint'(osc_req), 1);
      count_tmo(200, k);
      chk("R2 no tmo before ready", k, 0);
      chk("R2 req held while not ready", longint'(osc_req), 1);
      osc_hold = 1'b0;
      wait_tmo(t0, 400);
      chk("R2 tmo after ready", longint'(t0 >= 0), 1);

      // R4 / R5: sweep of mantissa, exponent and reference period
      foreach (mv[i]) begin
         foreach (rv[j]) begin
            run_combo("R4 gap", mv[i], rv[j], 5 + 2 * ((i + j) % 3), 5 + 2 * ((i + j) % 3));
         end
      end
      run_combo("R4 gap max mantissa", 255, 0, 3, 3);

      // R3: window averaging with round half up and the floor
      run_combo("R3 round 7/8", 1, 0, 7, 8);
      run_combo("R3 round 10/11", 3, 1, 10, 11);
      run_combo("R3 floor", 1, 0, 1, 1);
      run_combo("R3 even", 2, 2, 4, 4);

      // R6: zero mantissa stays silent
      setup(0, 3, 7, 7);
      en = 1'b1;
      count_tmo(600, k);
      chk("R6 zero mantissa", k, 0);

      // R7: periodic recalibration spacing and brief request
      setup(1, 4, 7, 7);
      en = 1'b1;
      wait_req(1'b1, ra, 50);
      wait_req(1'b0, fa, 200);
      wait_req(1'b1, rb, 1000);
      wait_req(1'b0, fb, 200);
      wait_req(1'b1, rc2, 1000);
      chk("R7 recal spacing", rc2 - rb, RECAL_MS * 7);
      chk_rng("R2 request length", fb - rb, 4 * 7, 5 * 7 + 8);
      chk("R7 first request seen", longint'(ra >= 0 && fa > ra), 1);

      // R8: recalibration picks up a new reference period
      wait_req(1'b0, fb, 200);
      per_a = 12;
      per_b = 12;
      wait_req(1'b1, rb, 1000);
      wait_req(1'b0, fb, 300);
      wait_tmo(t1, 1000);
      wait_tmo(t2, 1000);
      wait_tmo(t3, 1000);
      chk("R8 new spacing", t2 - t1, 16 * 12);
      chk("R8 new spacing", t3 - t2, 16 * 12);

      // R9: disable in the middle of a calibration
      setup(1, 0, 9, 9);
      en = 1'b1;
      repeat (8) @(negedge clk);
      chk("R9 req during cal", longint'(osc_req), 1);
      en = 1'b0;
      @(negedge clk);
      chk("R9 req drops", longint'(osc_req), 0);
      count_tmo(300, k);
      chk("R9 silent while off", k, 0);
      chk("R9 req stays low", longint'(osc_req), 0);
      en = 1'b1;
      @(negedge clk);
      chk("R9 fresh cal on re-enable", longint'(osc_req), 1);
      wait_tmo(t0, 300);
      wait_tmo(t1, 300);
      chk("R9 spacing after re-enable", t1 - t0, 9);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule